// File: doc/BRIEF.md
# Nine-bit multiprocessor UART with address filter

This block is a serial transmitter and receiver with an optional nine-bit framing mode for shared multi-drop lines. In nine-bit mode every frame carries one extra bit after the data bits. A 1 in that bit marks the frame as an address and a 0 marks it as data. With the address filter on, the receiver compares each address frame against a programmable compare value. It keeps only the data frames that follow a matching address, so a node on a busy bus sees only its own traffic.

Software reaches the block through a four-entry register port. The entries are the data window (a write queues a byte to send, a read takes the received byte), control, the address compare value and status. Bit timing comes from an external baud tick that pulses OVS times per bit period. A driver-enable output keys a half-duplex line transceiver, and its active level is programmable. A single level-sensitive interrupt reports received bytes and receive errors. A control bit can limit it to errors only.

Top module: `mpuart`

## Requirements
- R1: With control bit 0 (nine-bit mode) clear, each byte written to register 0 goes out on `uart_tx` as a start bit of 0, then eight data bits least-significant first, then a stop bit of 1. Each bit lasts OVS baud ticks, and the line idles at 1.
- R2: With control bit 0 set, a tenth bit is sent between the last data bit and the stop bit. Its value is control bit 1 as it stood when the byte was written.
- R3: A received frame with a valid stop bit is held in register 0 and sets status bit 0. A read of register 0 returns the byte and clears status bit 0.
- R4: With nine-bit mode on and the filter off (control bit 4 clear), every frame is stored. Its ninth bit is reported in status bit 4.
- R5: With nine-bit mode and the filter on, address frames (ninth bit 1) are never stored. They only update the match state: a match means the byte equals register 2. Data frames (ninth bit 0) are stored only if the most recent address frame matched. All others are discarded.
- R6: The driver is enabled from before the start bit of the first queued frame until the stop bit of the last back-to-back frame ends, with no gap between frames. With control bit 2 clear `drv_en` is 1 when active; with bit 2 set it is 0 when active.
- R7: A frame whose stop bit samples 0 sets status bit 1 (framing error), is not stored, and does not change the match state. Writing status with bit 1 set clears the flag. The receiver does not start a new frame until the line returns to 1.
- R8: A byte stored while status bit 0 is still set sets status bit 2 (overrun), and the new byte replaces the old one. Writing status with bit 2 set clears the flag.
- R9: `irq` is high while a framing or overrun error is flagged. It is also high while a byte is held, unless control bit 3 (data interrupt off) is set, in which case only errors raise it.
- R10: After reset `uart_tx` is 1, `drv_en` is 0, `irq` is 0 and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, OVS per bit period |
| reg_sel | input | 2 | Register select: 0 data, 1 control, 2 compare, 3 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of register 0 pops the received byte) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| uart_tx | output | 1 | Serial transmit line |
| uart_rx | input | 1 | Serial receive line |
| drv_en | output | 1 | Line driver enable, polarity from control bit 2 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with OVS = 4 and a baud tick every four clocks, so a bit lasts sixteen clocks. At that rate a full nine-bit frame takes under two hundred clocks, and every filter sequence, overrun and back-to-back transmit fits in a short run. DATA_W and SYNC stay at their defaults of 8 and 2, so the bench exercises the full byte path and the two-stage input synchronizer that a real line would see. OVS = 4 is the smallest setting the block accepts, and it puts the receiver's mid-bit sample only two ticks after the detected start edge, which tests the start-bit check at its tightest timing.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

   // control register fields, bit 4 down to bit 0
   typedef struct packed {
      logic filt_en;
      logic data_irq_off;
      logic de_low;
      logic tx_ninth;
      logic mp_en;
   } ctrl_t;

   localparam int CTRL_W = 5;
   localparam int STAT_W = 5;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_CMP  = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_BITS,
      RX_STOP,
      RX_WAIT_HI
   } rx_state_e;

endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_ninth,
   input  logic              wr_mp,
   output logic              full_o,
   output logic              busy_o,
   output logic              tx_o
);
   localparam int FW  = DATA_W + 3;
   localparam int CW  = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int BCW = $clog2(FW + 1);

   logic              hold_v;
   logic [DATA_W-1:0] hold_d;
   logic              hold_n;
   logic              hold_mp;
   logic              busy;
   logic [FW-1:0]     sh;
   logic [CW-1:0]     cnt;
   logic [BCW-1:0]    left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v  <= 1'b0;
         hold_d  <= '0;
         hold_n  <= 1'b0;
         hold_mp <= 1'b0;
         busy    <= 1'b0;
         sh      <= '1;
         cnt     <= '0;
         left    <= '0;
      end else begin
         if (wr && !hold_v) begin
            hold_v  <= 1'b1;
            hold_d  <= wr_data;
            hold_n  <= wr_ninth;
            hold_mp <= wr_mp;
         end
         if (!busy && hold_v) begin
            busy   <= 1'b1;
            hold_v <= 1'b0;
            sh     <= {1'b1, (hold_mp ? hold_n : 1'b1), hold_d, 1'b0};
            left   <= hold_mp ? BCW'(FW) : BCW'(FW - 1);
            cnt    <= '0;
         end else if (busy && tick) begin
            if (cnt == CW'(OVS - 1)) begin
               cnt  <= '0;
               sh   <= {1'b1, sh[FW-1:1]};
               left <= left - BCW'(1);
               if (left == BCW'(1))
                  busy <= 1'b0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   assign full_o = hold_v;
   assign busy_o = busy;
   assign tx_o   = busy ? sh[0] : 1'b1;

   AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && left == BCW'(1)) |-> tx_o) else $error("stop bit not high"); // R1

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
   import mpuart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_i,
   input  logic              mp_en,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              ninth_o,
   output logic              stop_ok_o
);
   localparam int CW   = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int HALF = OVS / 2;
   localparam int IW   = $clog2(DATA_W + 2);

   logic rxs;

   generate
      if (SYNC == 1) begin : g_sync1
         logic q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 1'b1;
            else        q <= rx_i;
         assign rxs = q;
      end else begin : g_syncn
         logic [SYNC-1:0] q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= '1;
            else        q <= {q[SYNC-2:0], rx_i};
         assign rxs = q[SYNC-1];
      end
   endgenerate

   rx_state_e       st;
   logic [CW-1:0]   cnt;
   logic [IW-1:0]   idx;
   logic [DATA_W:0] sh;
   logic            mp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         cnt       <= '0;
         idx       <= '0;
         sh        <= '0;
         mp_q      <= 1'b0;
         done_o    <= 1'b0;
         data_o    <= '0;
         ninth_o   <= 1'b0;
         stop_ok_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               if (tick && !rxs) begin
                  st   <= RX_START;
                  cnt  <= '0;
                  mp_q <= mp_en;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt == CW'(HALF - 1)) begin
                     cnt <= '0;
                     idx <= '0;
                     st  <= rxs ? RX_IDLE : RX_BITS;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
            end
            RX_BITS: begin
               if (tick) begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt <= '0;
                     sh  <= {rxs, sh[DATA_W:1]};
                     idx <= idx + IW'(1);
                     if (idx == (mp_q ? IW'(DATA_W) : IW'(DATA_W - 1)))
                        st <= RX_STOP;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt       <= '0;
                     done_o    <= 1'b1;
                     stop_ok_o <= rxs;
                     data_o    <= mp_q ? sh[DATA_W-1:0] : sh[DATA_W:1];
                     ninth_o   <= mp_q & sh[DATA_W];
                     st        <= rxs ? RX_IDLE : RX_WAIT_HI;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
            end
            RX_WAIT_HI: begin
               if (rxs) st <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("frame done longer than one cycle"); // R3

endmodule

// File: rtl/mpuart_filter.sv
module mpuart_filter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] data,
   input  logic              ninth,
   input  logic              stop_ok,
   input  logic              filt_act,
   input  logic [DATA_W-1:0] cmp,
   input  logic              rd_clear,
   input  logic              ferr_clear,
   input  logic              ovr_clear,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ninth,
   output logic              ferr,
   output logic              ovr
);
   logic match_q;
   logic keep;

   assign keep = stop_ok && !(filt_act && (ninth || !match_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q  <= 1'b0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
         rx_ninth <= 1'b0;
         ferr     <= 1'b0;
         ovr      <= 1'b0;
      end else begin
         if (rd_clear)   rx_valid <= 1'b0;
         if (ferr_clear) ferr     <= 1'b0;
         if (ovr_clear)  ovr      <= 1'b0;
         if (done) begin
            if (!stop_ok) begin
               ferr <= 1'b1;
            end else begin
               if (ninth)
                  match_q <= (data == cmp);
               if (keep) begin
                  if (rx_valid && !rd_clear)
                     ovr <= 1'b1;
                  rx_valid <= 1'b1;
                  rx_data  <= data;
                  rx_ninth <= ninth;
               end
            end
         end
      end
   end

   AST_ADDR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && stop_ok && ninth && filt_act && !rd_clear) |=> (rx_valid == $past(rx_valid)))
      else $error("address frame stored under filter"); // R5

   AST_FERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !stop_ok) |=> ferr) else $error("framing error not flagged"); // R7

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && keep && rx_valid && !rd_clear) |=> ovr) else $error("overrun not flagged"); // R8

endmodule

// File: rtl/mpuart.sv
module mpuart
   import mpuart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              uart_tx,
   input  logic              uart_rx,
   output logic              drv_en,
   output logic              irq
);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_W < STAT_W) begin : g_bad_width
         $error("DATA_W too narrow for control and status fields");
      end
      if (SYNC < 1) begin : g_bad_sync
         $error("SYNC must be at least 1");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] cmp_q;
   reg_sel_e          sel;

   assign sel = reg_sel_e'(reg_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmp_q  <= '0;
      end else if (reg_wr) begin
         if (sel == SEL_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (sel == SEL_CMP)  cmp_q  <= reg_wdata;
      end
   end

   logic tx_full, tx_busy;

   mpuart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .wr       (reg_wr && sel == SEL_DATA),
      .wr_data  (reg_wdata),
      .wr_ninth (ctrl_q.tx_ninth),
      .wr_mp    (ctrl_q.mp_en),
      .full_o   (tx_full),
      .busy_o   (tx_busy),
      .tx_o     (uart_tx)
   );

   logic              fr_done, fr_ninth, fr_stop_ok;
   logic [DATA_W-1:0] fr_data;

   mpuart_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC(SYNC)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .rx_i      (uart_rx),
      .mp_en     (ctrl_q.mp_en),
      .done_o    (fr_done),
      .data_o    (fr_data),
      .ninth_o   (fr_ninth),
      .stop_ok_o (fr_stop_ok)
   );

   logic              rx_valid, rx_ninth, ferr, ovr;
   logic [DATA_W-1:0] rx_data;

   mpuart_filter #(.DATA_W(DATA_W)) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (fr_done),
      .data       (fr_data),
      .ninth      (fr_ninth),
      .stop_ok    (fr_stop_ok),
      .filt_act   (ctrl_q.filt_en && ctrl_q.mp_en),
      .cmp        (cmp_q),
      .rd_clear   (reg_rd && sel == SEL_DATA),
      .ferr_clear (reg_wr && sel == SEL_STAT && reg_wdata[1]),
      .ovr_clear  (reg_wr && sel == SEL_STAT && reg_wdata[2]),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_ninth   (rx_ninth),
      .ferr       (ferr),
      .ovr        (ovr)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_DATA: reg_rdata = rx_data;
         SEL_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
         SEL_CMP:  reg_rdata = cmp_q;
         SEL_STAT: reg_rdata[STAT_W-1:0] = {rx_ninth, tx_full, ovr, ferr, rx_valid};
         default:  reg_rdata = '0;
      endcase
   end

   assign drv_en = (tx_busy || tx_full) ^ ctrl_q.de_low;
   assign irq    = ferr || ovr || (rx_valid && !ctrl_q.data_irq_off);

   AST_DE_DURING_TX: assert property (@(posedge clk) disable iff (!rst_n)
      !uart_tx |-> (drv_en != ctrl_q.de_low)) else $error("line driven low without driver enable"); // R6

endmodule

// File: tb/mpuart_tb_top.sv
`timescale 1ns/1ps
module mpuart_tb_top;
   localparam int DW    = 8;
   localparam int OVS   = 4;
   localparam int TDIV  = 4;
   localparam int BITC  = OVS * TDIV;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          baud_tick = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          uart_tx;
   logic          uart_rx = 1'b1;
   logic          drv_en;
   logic          irq;

   int total = 0;
   int bad   = 0;
   int wd    = 0;

   always #2.5 clk = ~clk;

   mpuart #(.DATA_W(DW), .OVS(OVS), .SYNC(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .uart_tx(uart_tx), .uart_rx(uart_rx), .drv_en(drv_en), .irq(irq)
   );

   int tdiv_cnt = 0;
   always @(negedge clk) begin
      tdiv_cnt  <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
      baud_tick <= (tdiv_cnt == TDIV - 1);
   end

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd == 150000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [DW-1:0] val);
      @(negedge clk);
      reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [DW-1:0] val);
      @(negedge clk);
      reg_sel = sel; reg_rd = 1'b1;
      #1 val = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic send_rx(input logic [DW-1:0] d, input logic use9, input logic nine, input logic stopb);
      @(negedge clk);
      uart_rx = 1'b0;
      repeat (BITC) @(negedge clk);
      for (int i = 0; i < DW; i++) begin
         uart_rx = d[i];
         repeat (BITC) @(negedge clk);
      end
      if (use9) begin
         uart_rx = nine;
         repeat (BITC) @(negedge clk);
      end
      uart_rx = stopb;
      repeat (BITC) @(negedge clk);
      uart_rx = 1'b1;
      repeat (2 * BITC) @(negedge clk);
   endtask

   // decode one frame from uart_tx, checking the driver level at each bit centre
   task automatic capture_tx(input string tag, input logic use9, input logic de_act,
                             input logic [DW-1:0] exp_d, input logic exp_n);
      logic [DW-1:0] d;
      logic          n;
      logic          de_ok;
      de_ok = 1'b1;
      n = 1'b0;
      @(negedge clk);
      while (uart_tx) @(negedge clk);
      repeat (BITC / 2) @(negedge clk);
      chk({tag, " start bit"}, uart_tx, 1'b0);
      for (int i = 0; i < DW; i++) begin
         repeat (BITC) @(negedge clk);
         d[i] = uart_tx;
         if (drv_en !== de_act) de_ok = 1'b0;
      end
      if (use9) begin
         repeat (BITC) @(negedge clk);
         n = uart_tx;
      end
      repeat (BITC) @(negedge clk);
      chk({tag, " stop bit"}, uart_tx, 1'b1);
      chk({tag, " data"}, d, exp_d);
      if (use9) chk({tag, " ninth bit"}, n, exp_n);
      chk({tag, " R6 driver active in frame"}, de_ok, 1'b1);
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      chk("R10 tx idle", uart_tx, 1'b1);
      chk("R10 drv_en", drv_en, 1'b0);
      chk("R10 irq", irq, 1'b0);
      reg_read(2'd3, v);
      chk("R10 status", v, 8'h00);
   endtask

   task automatic t_tx8;
      reg_write(2'd1, 8'h00);
      reg_write(2'd0, 8'hA5);
      capture_tx("R1 8-bit frame", 1'b0, 1'b1, 8'hA5, 1'b0);
      repeat (BITC) @(negedge clk);
      chk("R6 idle after frame", drv_en, 1'b0);
   endtask

   task automatic t_tx9;
      reg_write(2'd1, 8'h03);
      reg_write(2'd0, 8'h3C);
      reg_write(2'd1, 8'h01);
      capture_tx("R2 ninth=1", 1'b1, 1'b1, 8'h3C, 1'b1);
      reg_write(2'd0, 8'hC3);
      capture_tx("R2 ninth=0", 1'b1, 1'b1, 8'hC3, 1'b0);
      repeat (BITC) @(negedge clk);
   endtask

   task automatic t_de_polarity;
      int span;
      reg_write(2'd1, 8'h04);
      chk("R6 active-low idle level", drv_en, 1'b1);
      reg_write(2'd0, 8'h81);
      reg_write(2'd0, 8'h7E);
      span = 0;
      while (uart_tx) @(negedge clk);
      while (drv_en == 1'b0 && span < 1000) begin
         @(negedge clk);
         span++;
      end
      chk("R6 back-to-back span in window", (span >= 300 && span <= 340), 1'b1);
      chk("R6 line idle at end", uart_tx, 1'b1);
      reg_write(2'd1, 8'h00);
      chk("R6 active-high idle level", drv_en, 1'b0);
   endtask

   task automatic t_rx8;
      logic [DW-1:0] v;
      reg_write(2'd1, 8'h00);
      send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
      reg_read(2'd3, v);
      chk("R3 valid set", v, 8'h01);
      chk("R9 irq on data", irq, 1'b1);
      reg_read(2'd0, v);
      chk("R3 byte", v, 8'h5A);
      reg_read(2'd3, v);
      chk("R3 valid cleared by read", v, 8'h00);
      chk("R9 irq clear", irq, 1'b0);
   endtask

   task automatic t_rx9;
      logic [DW-1:0] v;
      reg_write(2'd1, 8'h01);
      send_rx(8'h77, 1'b1, 1'b1, 1'b1);
      reg_read(2'd3, v);
      chk("R4 status ninth and valid", v, 8'h11);
      reg_read(2'd0, v);
      chk("R4 byte", v, 8'h77);
      send_rx(8'h23, 1'b1, 1'b0, 1'b1);
      reg_read(2'd3, v);
      chk("R4 data frame ninth clear", v, 8'h01);
      reg_read(2'd0, v);
      chk("R4 data byte", v, 8'h23);
   endtask

   task automatic t_filter;
      logic [DW-1:0] v;
      reg_write(2'd2, 8'h42);
      reg_write(2'd1, 8'h11);
      send_rx(8'h10, 1'b1, 1'b1, 1'b1);
      send_rx(8'h11, 1'b1, 0, 1'b1);
      reg_read(2'd3, v);
      chk("R5 unmatched data dropped", v, 8'h00);
      send_rx(8'h42, 1'b1, 1'b1, 1'b1);
      reg_read(2'd3, v);
      chk("R5 address not stored", v, 8'h00);
      chk("R5 irq quiet on address", irq, 1'b0);
      send_rx(8'h99, 1'b1, 1'b0, 1'b1);
      chk("R5 irq on matched data", irq, 1'b1);
      reg_read(2'd0, v);
      chk("R5 matched data", v, 8'h99);
      send_rx(8'h98, 1'b1, 1'b0, 1'b1);
      reg_read(2'd0, v);
      chk("R5 match persists", v, 8'h98);
      send_rx(8'h43, 1'b1, 1'b1, 1'b1);
      send_rx(8'h55, 1'b1, 1'b0, 1'b1);
      reg_read(2'd3, v);
      chk("R5 new mismatch drops data", v, 8'h00);
   endtask

   task automatic t_overrun;
      logic [DW-1:0] v;
      reg_write(2'd1, 8'h08);
      send_rx(8'h12, 1'b0, 1'b0, 1'b1);
      reg_read(2'd3, v);
      chk("R9 data held", v, 8'h01);
      chk("R9 data irq disabled", irq, 1'b0);
      send_rx(8'h34, 1'b0, 1'b0, 1'b1);
      reg_read(2'd3, v);
      chk("R8 overrun flagged", v, 8'h05);
      chk("R9 irq on overrun", irq, 1'b1);
      reg_write(2'd3, 8'h04);
      reg_read(2'd3, v);
      chk("R8 overrun cleared", v, 8'h01);
      reg_read(2'd0, v);
      chk("R8 newer byte kept", v, 8'h34);
      chk("R9 irq low again", irq, 1'b0);
   endtask

   task automatic t_framing;
      logic [DW-1:0] v;
      reg_write(2'd1, 8'h08);
      send_rx(8'h66, 1'b0, 1'b0, 1'b0);
      reg_read(2'd3, v);
      chk("R7 framing flagged, not stored", v, 8'h02);
      chk("R9 irq on framing error", irq, 1'b1);
      reg_write(2'd3, 8'h02);
      reg_read(2'd3, v);
      chk("R7 framing cleared", v, 8'h00);
      chk("R7 irq cleared", irq, 1'b0);
      reg_write(2'd1, 8'h00);
      send_rx(8'h21, 1'b0, 1'b0, 1'b1);
      reg_read(2'd0, v);
      chk("R7 receiver recovers", v, 8'h21);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_tx8();
      t_tx9();
      t_de_polarity();
      t_rx8();
      t_rx9();
      t_filter();
      t_overrun();
      t_framing();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule